// File: doc/BRIEF.md
# Multichannel DMA Layer Control Registers

This block holds the software-visible control and status state of a multichannel DMA access layer. A processor reaches it over a simple synchronous register bus that uses direct register numbers: one strobe writes and one strobe reads, and there is no handshake. The block keeps the layer configuration, an error status word and an interrupt enable word. It keeps a channel-active mask for each direction, set and cleared through separate set and reset registers. It keeps end-of-buffer and descriptor-error status bits per channel. It also holds one descriptor-table pointer per channel and one buffer-size byte per receive channel.

The DMA engine is a separate block. It reads the active masks from the block's outputs and reports per-channel events on single-cycle pulse inputs. The block turns the status words into five level interrupt outputs, each gated by its enable bit. The transmit channel count `TX_CH` and the receive channel count `RX_CH` are parameters, each at most 32. Channel c of a direction uses register bit 31-c in every per-channel word. Register numbers are 10 bits wide.

The house style calls for a state machine, but none is used. The block is a register file with no sequencing, so it is built as plain registers and write decode.

Top module: `mcdma_ctl_regs`

## Requirements
- R1: After reset the configuration register (0x180) reads 0x0007C000. Every other register reads 0, and all active-mask and interrupt outputs are 0.
- R2: A write to 0x180 with bit 31 set returns the whole block to its R1 values. This includes the descriptor pointers and buffer sizes, and 0x180 then reads 0x0007C000.
- R3: A write to 0x180 with bit 31 clear stores the written value ANDed with 0x00FFC087.
- R4: The interrupt enable register (0x182) keeps bits 4:0 only. Bit 0 enables system error, bit 1 transmit end-of-buffer, bit 2 receive end-of-buffer, bit 3 transmit descriptor error and bit 4 receive descriptor error.
- R5: Writing the transmit set register (0x184) ORs bits 31:32-TX_CH of the data into the transmit active mask. Writing the transmit reset register (0x185) clears the matching bits. Either register reads back the mask. `tx_active[c]` equals mask bit 31-c.
- R6: The receive set (0x190) and reset (0x191) registers do the same for the receive mask. The receive mask keeps bits 31:32-RX_CH, and `rx_active[c]` equals mask bit 31-c.
- R7: A pulse on a per-channel event input sets bit 31-c of its status register. The status registers are transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive end-of-buffer 0x192 and receive descriptor error 0x193. A pulse on `sys_err_evt[k]` sets bit k of the error status register (0x181).
- R8: Each status register of R7 clears the bits written as one and keeps the others. An event and a clear in the same cycle leave the bit set.
- R9: Each interrupt output is the OR of its status register, ANDed with its R4 enable bit, and follows the register state one edge after a change.
- R10: Transmit descriptor pointers sit at 0x1A0+i for i < TX_CH, and receive descriptor pointers at 0x1C0+i for i < RX_CH. All 32 bits are stored. Numbers beyond the channel count are not part of the array.
- R11: The receive buffer size registers sit at 0x1E0+i for i < RX_CH and keep bits 7:0 only.
- R12: A read strobe presents the addressed value on `reg_rdata` after the next rising edge, and `reg_rdata` holds when no read is strobed. Unmapped numbers read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 10 | Register number |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_eob_evt | input | TX_CH | Transmit end-of-buffer event pulses |
| rx_eob_evt | input | RX_CH | Receive end-of-buffer event pulses |
| tx_derr_evt | input | TX_CH | Transmit descriptor error pulses |
| rx_derr_evt | input | RX_CH | Receive descriptor error pulses |
| sys_err_evt | input | 32 | Error status set pulses |
| tx_active | output | TX_CH | Transmit channel active mask |
| rx_active | output | RX_CH | Receive channel active mask |
| irq_sys_err | output | 1 | System error interrupt |
| irq_tx_eob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rx_eob | output | 1 | Receive end-of-buffer interrupt |
| irq_tx_derr | output | 1 | Transmit descriptor error interrupt |
| irq_rx_derr | output | 1 | Receive descriptor error interrupt |

## Verification
Read data is due one rising edge after the read strobe. The bench's driver queues the expected word when it raises the strobe, and its monitor pops and compares it at the next falling edge. Writes and event pulses update the registers, the active masks and the interrupts at the same edge that captures them. The bench therefore checks those ports at the falling edge that ends the stimulus task. No check samples at a rising edge.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;
    localparam int REG_NUM_W = 10;
    localparam int IE_W      = 5;

    localparam logic [REG_NUM_W-1:0] RN_CFG     = 10'h180;
    localparam logic [REG_NUM_W-1:0] RN_ERRSTAT = 10'h181;
    localparam logic [REG_NUM_W-1:0] RN_IRQEN   = 10'h182;
    localparam logic [REG_NUM_W-1:0] RN_TX_SET  = 10'h184;
    localparam logic [REG_NUM_W-1:0] RN_TX_CLR  = 10'h185;
    localparam logic [REG_NUM_W-1:0] RN_TX_EOB  = 10'h186;
    localparam logic [REG_NUM_W-1:0] RN_TX_DERR = 10'h187;
    localparam logic [REG_NUM_W-1:0] RN_RX_SET  = 10'h190;
    localparam logic [REG_NUM_W-1:0] RN_RX_CLR  = 10'h191;
    localparam logic [REG_NUM_W-1:0] RN_RX_EOB  = 10'h192;
    localparam logic [REG_NUM_W-1:0] RN_RX_DERR = 10'h193;
    localparam int RN_TX_PTR_BASE = 'h1A0;
    localparam int RN_RX_PTR_BASE = 'h1C0;
    localparam int RN_RX_BSZ_BASE = 'h1E0;

    localparam logic [31:0] CFG_RESET_VAL = 32'h0007_C000;
    localparam logic [31:0] CFG_KEEP_MASK = 32'h00FF_C087;
    localparam int CFG_SOFT_RST_BIT = 31;

    localparam int IE_SYS     = 0;
    localparam int IE_TX_EOB  = 1;
    localparam int IE_RX_EOB  = 2;
    localparam int IE_TX_DERR = 3;
    localparam int IE_RX_DERR = 4;
endpackage

// File: rtl/mcdma_w1c_stat.sv
module mcdma_w1c_stat #(
    parameter int N         = 4,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         clr_we,
    input  logic [31:0]  clr_word,
    input  logic [N-1:0] set_evt,
    output logic [N-1:0] stat,
    output logic [31:0]  view
);
    function automatic int bitpos(input int c);
        return MSB_FIRST ? 31 - c : c;
    endfunction

    logic [N-1:0] clr_bits;

    always_comb begin
        view = '0;
        clr_bits = '0;
        for (int c = 0; c < N; c++) begin
            view[bitpos(c)] = stat[c];
            clr_bits[c] = clr_we & clr_word[bitpos(c)];
        end
    end

    // an event in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stat <= '0;
        else if (soft_clr) stat <= '0;
        else               stat <= (stat & ~clr_bits) | set_evt;
    end
endmodule

// File: rtl/mcdma_active_mask.sv
module mcdma_active_mask #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         set_we,
    input  logic         rst_we,
    input  logic [31:0]  wdata,
    output logic [N-1:0] mask,
    output logic [31:0]  view
);
    logic [N-1:0] sel;

    always_comb begin
        view = '0;
        for (int c = 0; c < N; c++) begin
            view[31-c] = mask[c];
            sel[c] = wdata[31-c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask <= '0;
        else if (soft_clr) mask <= '0;
        else if (set_we)   mask <= mask | sel;
        else if (rst_we)   mask <= mask & ~sel;
    end
endmodule

// File: rtl/mcdma_ptr_bank.sv
module mcdma_ptr_bank import mcdma_pkg::*; #(
    parameter int N    = 4,
    parameter int W    = 32,
    parameter int BASE = 'h1A0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr,
    input  logic [REG_NUM_W-1:0] reg_num,
    input  logic                 reg_wr,
    input  logic [31:0]          wdata,
    output logic                 hit,
    output logic [31:0]          rdata
);
    logic [N-1:0] sel;
    logic [W-1:0] entry [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        assign sel[i] = (reg_num == REG_NUM_W'(BASE + i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                entry[i] <= '0;
            else if (soft_clr)         entry[i] <= '0;
            else if (reg_wr && sel[i]) entry[i] <= wdata[W-1:0];
        end
    end

    always_comb begin
        hit = |sel;
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (sel[i]) rdata = rdata | 32'(entry[i]);
    end
endmodule

// File: rtl/mcdma_ctl_regs.sv
module mcdma_ctl_regs import mcdma_pkg::*; #(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_NUM_W-1:0] reg_num,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [TX_CH-1:0]     tx_eob_evt,
    input  logic [RX_CH-1:0]     rx_eob_evt,
    input  logic [TX_CH-1:0]     tx_derr_evt,
    input  logic [RX_CH-1:0]     rx_derr_evt,
    input  logic [31:0]          sys_err_evt,
    output logic [TX_CH-1:0]     tx_active,
    output logic [RX_CH-1:0]     rx_active,
    output logic                 irq_sys_err,
    output logic                 irq_tx_eob,
    output logic                 irq_rx_eob,
    output logic                 irq_tx_derr,
    output logic                 irq_rx_derr
);
    localparam int BSZ_W = 8;

    function automatic logic wr_to(input logic [REG_NUM_W-1:0] rn);
        return reg_wr && (reg_num == rn);
    endfunction

    logic        soft_clr;
    logic [31:0] cfg_q;
    logic [IE_W-1:0] ier_q;
    logic [31:0] err_view, txa_view, rxa_view;
    logic [31:0] txeob_view, txderr_view, rxeob_view, rxderr_view;
    logic [31:0] err_stat;
    logic [TX_CH-1:0] txeob_q, txderr_q;
    logic [RX_CH-1:0] rxeob_q, rxderr_q;
    logic        txp_hit, rxp_hit, bsz_hit;
    logic [31:0] txp_rd, rxp_rd, bsz_rd;
    logic [31:0] rd_val;

    assign soft_clr = wr_to(RN_CFG) && reg_wdata[CFG_SOFT_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET_VAL;
            ier_q <= '0;
        end else if (soft_clr) begin
            cfg_q <= CFG_RESET_VAL;
            ier_q <= '0;
        end else begin
            if (wr_to(RN_CFG))   cfg_q <= reg_wdata & CFG_KEEP_MASK;
            if (wr_to(RN_IRQEN)) ier_q <= reg_wdata[IE_W-1:0];
        end
    end

    mcdma_active_mask #(.N(TX_CH)) u_txa (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .set_we(wr_to(RN_TX_SET)), .rst_we(wr_to(RN_TX_CLR)),
        .wdata(reg_wdata), .mask(tx_active), .view(txa_view));

    mcdma_active_mask #(.N(RX_CH)) u_rxa (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .set_we(wr_to(RN_RX_SET)), .rst_we(wr_to(RN_RX_CLR)),
        .wdata(reg_wdata), .mask(rx_active), .view(rxa_view));

    mcdma_w1c_stat #(.N(32), .MSB_FIRST(1'b0)) u_err (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr_to(RN_ERRSTAT)), .clr_word(reg_wdata),
        .set_evt(sys_err_evt), .stat(err_stat), .view(err_view));

    mcdma_w1c_stat #(.N(TX_CH), .MSB_FIRST(1'b1)) u_txeob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr_to(RN_TX_EOB)), .clr_word(reg_wdata),
        .set_evt(tx_eob_evt), .stat(txeob_q), .view(txeob_view));

    mcdma_w1c_stat #(.N(TX_CH), .MSB_FIRST(1'b1)) u_txderr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr_to(RN_TX_DERR)), .clr_word(reg_wdata),
        .set_evt(tx_derr_evt), .stat(txderr_q), .view(txderr_view));

    mcdma_w1c_stat #(.N(RX_CH), .MSB_FIRST(1'b1)) u_rxeob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr_to(RN_RX_EOB)), .clr_word(reg_wdata),
        .set_evt(rx_eob_evt), .stat(rxeob_q), .view(rxeob_view));

    mcdma_w1c_stat #(.N(RX_CH), .MSB_FIRST(1'b1)) u_rxderr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr_to(RN_RX_DERR)), .clr_word(reg_wdata),
        .set_evt(rx_derr_evt), .stat(rxderr_q), .view(rxderr_view));

    mcdma_ptr_bank #(.N(TX_CH), .W(32), .BASE(RN_TX_PTR_BASE)) u_txptr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_num(reg_num),
        .reg_wr(reg_wr), .wdata(reg_wdata), .hit(txp_hit), .rdata(txp_rd));

    mcdma_ptr_bank #(.N(RX_CH), .W(32), .BASE(RN_RX_PTR_BASE)) u_rxptr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_num(reg_num),
        .reg_wr(reg_wr), .wdata(reg_wdata), .hit(rxp_hit), .rdata(rxp_rd));

    mcdma_ptr_bank #(.N(RX_CH), .W(BSZ_W), .BASE(RN_RX_BSZ_BASE)) u_bsz (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_num(reg_num),
        .reg_wr(reg_wr), .wdata(reg_wdata), .hit(bsz_hit), .rdata(bsz_rd));

    assign irq_sys_err = ier_q[IE_SYS]     & |err_stat;
    assign irq_tx_eob  = ier_q[IE_TX_EOB]  & |txeob_q;
    assign irq_rx_eob  = ier_q[IE_RX_EOB]  & |rxeob_q;
    assign irq_tx_derr = ier_q[IE_TX_DERR] & |txderr_q;
    assign irq_rx_derr = ier_q[IE_RX_DERR] & |rxderr_q;

    always_comb begin
        case (reg_num)
            RN_CFG:                rd_val = cfg_q;
            RN_ERRSTAT:            rd_val = err_view;
            RN_IRQEN:              rd_val = 32'(ier_q);
            RN_TX_SET, RN_TX_CLR:  rd_val = txa_view;
            RN_TX_EOB:             rd_val = txeob_view;
            RN_TX_DERR:            rd_val = txderr_view;
            RN_RX_SET, RN_RX_CLR:  rd_val = rxa_view;
            RN_RX_EOB:             rd_val = rxeob_view;
            RN_RX_DERR:            rd_val = rxderr_view;
            default: begin
                if (txp_hit)      rd_val = txp_rd;
                else if (rxp_hit) rd_val = rxp_rd;
                else if (bsz_hit) rd_val = bsz_rd;
                else              rd_val = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end
endmodule

// File: rtl/mcdma_ctl_regs_chk.sv
module mcdma_ctl_regs_chk import mcdma_pkg::*; #(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_NUM_W-1:0] reg_num,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          reg_rdata,
    input logic [TX_CH-1:0]     tx_eob_evt,
    input logic [TX_CH-1:0]     tx_active,
    input logic [RX_CH-1:0]     rx_active,
    input logic [IE_W-1:0]      ier_q,
    input logic                 irq_sys_err,
    input logic                 irq_tx_eob,
    input logic                 irq_rx_eob,
    input logic                 irq_tx_derr,
    input logic                 irq_rx_derr
);
    logic cfg_soft, touches_ier;
    assign cfg_soft    = reg_wr && reg_num == RN_CFG && reg_wdata[31];
    assign touches_ier = reg_wr && (reg_num == RN_CFG || reg_num == RN_IRQEN);

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft |=> (tx_active == '0 && rx_active == '0 && !irq_sys_err && !irq_tx_eob
                      && !irq_rx_eob && !irq_tx_derr && !irq_rx_derr)); // R2

    AST_TX_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(tx_active)); // R5

    AST_RX_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(rx_active)); // R6

    AST_EOB_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eob_evt != '0 && ier_q[IE_TX_EOB] && !touches_ier) |=> irq_tx_eob); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R12
endmodule

bind mcdma_ctl_regs mcdma_ctl_regs_chk #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_eob_evt(tx_eob_evt),
    .tx_active(tx_active), .rx_active(rx_active), .ier_q(ier_q),
    .irq_sys_err(irq_sys_err), .irq_tx_eob(irq_tx_eob), .irq_rx_eob(irq_rx_eob),
    .irq_tx_derr(irq_tx_derr), .irq_rx_derr(irq_rx_derr));

// File: tb/mcdma_ctl_regs_test.sv
module mcdma_ctl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int TX_CH = 4;
    localparam int RX_CH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [9:0] reg_num = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [TX_CH-1:0] tx_eob_evt = '0, tx_derr_evt = '0, tx_active;
    logic [RX_CH-1:0] rx_eob_evt = '0, rx_derr_evt = '0, rx_active;
    logic [31:0] sys_err_evt = '0;
    logic irq_sys_err, irq_tx_eob, irq_rx_eob, irq_tx_derr, irq_rx_derr;

    int n_vec = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcdma_ctl_regs #(.TX_CH(TX_CH), .RX_CH(RX_CH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_eob_evt(tx_eob_evt),
        .rx_eob_evt(rx_eob_evt), .tx_derr_evt(tx_derr_evt), .rx_derr_evt(rx_derr_evt),
        .sys_err_evt(sys_err_evt), .tx_active(tx_active), .rx_active(rx_active),
        .irq_sys_err(irq_sys_err), .irq_tx_eob(irq_tx_eob), .irq_rx_eob(irq_rx_eob),
        .irq_tx_derr(irq_tx_derr), .irq_rx_derr(irq_rx_derr));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] rn, input logic [31:0] d);
        reg_wr = 1'b1; reg_num = rn; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] rn, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_num = rn;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // monitor: a read captured at a rising edge is compared at the following falling edge
    initial begin
        forever begin
            logic seen;
            @(posedge clk);
            seen = reg_rd;
            @(negedge clk);
            if (seen) check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_active", 32'(tx_active), 32'h0);
        check("R1 irqs", {27'd0, irq_sys_err, irq_tx_eob, irq_rx_eob, irq_tx_derr, irq_rx_derr}, 32'h0);
        rd(10'h180, 32'h0007C000, "R1 cfg");
        rd(10'h182, 32'h0, "R1 ier");
        rd(10'h184, 32'h0, "R1 txset");
        rd(10'h1A0, 32'h0, "R1 txptr0");
        // R3 configuration mask
        wr(10'h180, 32'h7FFFFFFF); rd(10'h180, 32'h00FFC087, "R3 cfg all");
        wr(10'h180, 32'h12345678); rd(10'h180, 32'h00344000, "R3 cfg pattern");
        // R4 enable width
        wr(10'h182, 32'hFFFFFFFF); rd(10'h182, 32'h0000001F, "R4 ier");
        // R5 transmit active set/reset
        wr(10'h184, 32'hA0000000);
        check("R5 tx_active", 32'(tx_active), 32'h5);
        rd(10'h184, 32'hA0000000, "R5 txset read");
        wr(10'h184, 32'h5FFFFFFF); rd(10'h185, 32'hF0000000, "R5 set or");
        wr(10'h185, 32'h40000000); rd(10'h185, 32'hB0000000, "R5 reset");
        check("R5 tx_active after reset", 32'(tx_active), 32'hD);
        // R6 receive active set/reset
        wr(10'h190, 32'hFFFFFFFF); rd(10'h190, 32'hC0000000, "R6 rxset");
        wr(10'h191, 32'h80000000); rd(10'h191, 32'h40000000, "R6 rxrst");
        check("R6 rx_active", 32'(rx_active), 32'h2);
        // R7 / R9 event sets status and raises interrupt
        tx_eob_evt = 4'b0010; @(negedge clk); tx_eob_evt = '0;
        check("R9 irq_tx_eob set", 32'(irq_tx_eob), 32'h1);
        rd(10'h186, 32'h40000000, "R7 txeob bit");
        // R8 write-one-to-clear
        wr(10'h186, 32'h80000000); rd(10'h186, 32'h40000000, "R8 wrong bit keeps");
        reg_wr = 1'b1; reg_num = 10'h186; reg_wdata = 32'h40000000; tx_eob_evt = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; tx_eob_evt = '0;
        rd(10'h186, 32'h40000000, "R8 event beats clear");
        wr(10'h186, 32'h40000000); rd(10'h186, 32'h0, "R8 cleared");
        check("R9 irq_tx_eob clear", 32'(irq_tx_eob), 32'h0);
        // R9 gating by enable
        rx_derr_evt = 2'b01; @(negedge clk); rx_derr_evt = '0;
        check("R9 irq_rx_derr", 32'(irq_rx_derr), 32'h1);
        rd(10'h193, 32'h80000000, "R7 rxderr bit");
        wr(10'h182, 32'h0000000F);
        check("R9 irq_rx_derr masked", 32'(irq_rx_derr), 32'h0);
        // R7 error status direct bits, R9 system error
        sys_err_evt = 32'h00000100; @(negedge clk); sys_err_evt = '0;
        check("R9 irq_sys_err", 32'(irq_sys_err), 32'h1);
        rd(10'h181, 32'h00000100, "R7 errstat");
        wr(10'h181, 32'h00000100); rd(10'h181, 32'h0, "R8 errstat clear");
        rx_eob_evt = 2'b10; @(negedge clk); rx_eob_evt = '0;
        rd(10'h192, 32'h40000000, "R7 rxeob ch1");
        check("R9 irq_rx_eob", 32'(irq_rx_eob), 32'h1);
        // R10 descriptor pointers
        wr(10'h1A3, 32'hDEADBEEF); rd(10'h1A3, 32'hDEADBEEF, "R10 txptr3");
        wr(10'h1A4, 32'h00000001); rd(10'h1A4, 32'h0, "R10 beyond tx count");
        wr(10'h1C1, 32'h12345678); rd(10'h1C1, 32'h12345678, "R10 rxptr1");
        wr(10'h1C2, 32'h00000055); rd(10'h1C2, 32'h0, "R10 beyond rx count");
        // R11 buffer sizes
        wr(10'h1E0, 32'hFFFFFFAB); rd(10'h1E0, 32'h000000AB, "R11 bsz0");
        wr(10'h1E2, 32'h00000077); rd(10'h1E2, 32'h0, "R11 beyond rx count");
        // R12 unmapped
        wr(10'h17F, 32'hFFFFFFFF); rd(10'h17F, 32'h0, "R12 unmapped");
        rd(10'h183, 32'h0, "R12 hole");
        // R2 soft reset
        tx_eob_evt = 4'b1000; @(negedge clk); tx_eob_evt = '0;
        check("R2 pre irq_tx_eob", 32'(irq_tx_eob), 32'h1);
        wr(10'h180, 32'h80000000);
        check("R2 tx_active", 32'(tx_active), 32'h0);
        check("R2 rx_active", 32'(rx_active), 32'h0);
        check("R2 irqs", {27'd0, irq_sys_err, irq_tx_eob, irq_rx_eob, irq_tx_derr, irq_rx_derr}, 32'h0);
        rd(10'h180, 32'h0007C000, "R2 cfg");
        rd(10'h182, 32'h0, "R2 ier");
        rd(10'h186, 32'h0, "R2 txeob");
        rd(10'h1A3, 32'h0, "R2 txptr3");
        rd(10'h1C1, 32'h0, "R2 rxptr1");
        rd(10'h1E0, 32'h0, "R2 bsz0");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule